// File: doc/BRIEF.md
# Clock-Stop Gating Controller

This block stops and restarts two groups of output clocks without glitches. One group is driven by a fast processor clock and the other by a slower bus clock. Each group has its own active-low stop request, and either request may change at any time with no relation to the clocks. Each request is brought into the domain of the clock it controls through a two-stage synchronizer. The synchronized value then sets a gate enable that is registered on the falling edge of that clock. Each gated output is its source clock ANDed with that enable. As a result, an output can only freeze while low and can only resume at a rising edge, which gives a complete high phase.

The bus domain has two more outputs, a free-running one and an early-phase one. The bus stop request never affects them. A global active-high power-down input overrides everything. While it is asserted, every output, including the exempt pair, is held low and both stop requests are ignored. Power-down is synchronized separately in each clock domain.

Top module: `clkstop_ctrl`

## Requirements
- R1: After reset, with both stop requests high and power-down low, every output equals its source clock: high during each high phase and low during each low phase.
- R2: An output that is stopped rests at 0 through both phases of its source clock.
- R3: When the processor stop request changes at a falling edge of the processor clock, the processor outputs still show the old state in the high phase that begins at the second rising edge after the change. They show the new state from the third rising edge onward, which is fewer than 4 processor cycles.
- R4: The bus stop request follows the same timing, counted in bus-clock rising edges: the old state in the second high phase after the change, the new state from the third.
- R5: On restart, the first high phase of a gated output starts with its source clock's rising edge and stays high until the following falling edge. It is a full-width pulse.
- R6: The free-running and early-phase bus outputs keep following the bus clock whatever the bus stop request is.
- R7: Stopping one group leaves the other group's outputs running.
- R8: While power-down is high, every output, the exempt pair included, rests at 0 whatever the stop requests are. Once power-down falls, each output returns to the state its stop request selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk_i | input | 1 | Processor-group source clock |
| bus_clk_i | input | 1 | Bus-group source clock |
| rst_n_i | input | 1 | Asynchronous active-low reset; enables return to running |
| cpu_stop_n_i | input | 1 | Asynchronous active-low stop request for the processor group |
| bus_stop_n_i | input | 1 | Asynchronous active-low stop request for the gated bus group |
| pd_i | input | 1 | Asynchronous active-high power-down, forces all outputs low |
| cpu_clk_o | output | N_CPU | Gated processor clocks |
| bus_clk_o | output | N_BUS | Gated bus clocks |
| bus_free_o | output | 1 | Bus clock exempt from the bus stop request |
| bus_early_o | output | 1 | Early-phase bus clock exempt from the bus stop request |

## Verification
Directed edge-counted sequences change one stop request at a falling edge. They sample the outputs in the second and third high phases that follow, which separates a correct two-stage latency from one that is a stage short or a stage long. Each restart is sampled just after the rising edge and just before the falling edge, so a runt pulse or a late enable is caught. While one group is stopped, the other group and the exempt pair are sampled, which exposes any cross-coupling or wrongly gated exempt output. Seeded random combinations of both stop requests and power-down are then held until settled and checked in both clock phases. This distinguishes the power-down override from an ordinary stop.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;

    // Registered state of one gate: the enable that is ANDed with the clock.
    typedef struct packed {
        logic en;
    } gate_state_t;

    localparam gate_state_t GATE_RUN = '{en: 1'b1};

endpackage

// File: rtl/clkstop_sync.sv
module clkstop_sync #(
    parameter int STAGES  = 2,
    parameter bit RST_VAL = 1'b0
) (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], d_i};
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) chain_q <= {STAGES{RST_VAL}};
        else          chain_q <= chain_d;
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/clkstop_gate.sv
module clkstop_gate
    import clkstop_pkg::*;
#(
    parameter int N         = 1,
    parameter bit STOPPABLE = 1'b1
) (
    input  logic         clk_i,
    input  logic         rst_n_i,
    input  logic         stop_s_i,
    input  logic         pd_s_i,
    output logic [N-1:0] clk_o
);
    gate_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.en = !pd_s_i && !(STOPPABLE && stop_s_i);
    end

    // Enable moves only at the falling edge, so it is steady across every high phase.
    always_ff @(negedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) st_q <= GATE_RUN;
        else          st_q <= st_d;
    end

    for (genvar i = 0; i < N; i++) begin : g_out
        assign clk_o[i] = clk_i & st_q.en;
    end

    // Sampled at falling edges, where the output shows the high phase just ending.
    a_r8_pd_rests_low: assert property (@(negedge clk_i) disable iff (!rst_n_i)
        $past(pd_s_i) |-> clk_o == '0);

    a_r2_stop_rests_low: assert property (@(negedge clk_i) disable iff (!rst_n_i)
        $past(STOPPABLE && stop_s_i) |-> clk_o == '0);

    a_r1_runs_when_enabled: assert property (@(negedge clk_i) disable iff (!rst_n_i)
        $past(!pd_s_i && !(STOPPABLE && stop_s_i)) |-> clk_o == '1);

    a_r2_low_phase_low: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        clk_o == '0);
endmodule

// File: rtl/clkstop_ctrl.sv
module clkstop_ctrl #(
    parameter int N_CPU       = 3,
    parameter int N_BUS       = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic             cpu_clk_i,
    input  logic             bus_clk_i,
    input  logic             rst_n_i,
    input  logic             cpu_stop_n_i,
    input  logic             bus_stop_n_i,
    input  logic             pd_i,
    output logic [N_CPU-1:0] cpu_clk_o,
    output logic [N_BUS-1:0] bus_clk_o,
    output logic             bus_free_o,
    output logic             bus_early_o
);
    localparam int N_EXEMPT = 2;

    logic cpu_run_s, cpu_pd_s, bus_run_s, bus_pd_s;
    logic [N_EXEMPT-1:0] exempt_clk;

    clkstop_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cpu_stop_sync (
        .clk_i(cpu_clk_i), .rst_n_i(rst_n_i), .d_i(cpu_stop_n_i), .q_o(cpu_run_s));
    clkstop_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_cpu_pd_sync (
        .clk_i(cpu_clk_i), .rst_n_i(rst_n_i), .d_i(pd_i), .q_o(cpu_pd_s));
    clkstop_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_bus_stop_sync (
        .clk_i(bus_clk_i), .rst_n_i(rst_n_i), .d_i(bus_stop_n_i), .q_o(bus_run_s));
    clkstop_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_bus_pd_sync (
        .clk_i(bus_clk_i), .rst_n_i(rst_n_i), .d_i(pd_i), .q_o(bus_pd_s));

    clkstop_gate #(.N(N_CPU), .STOPPABLE(1'b1)) u_cpu_gate (
        .clk_i(cpu_clk_i), .rst_n_i(rst_n_i), .stop_s_i(!cpu_run_s),
        .pd_s_i(cpu_pd_s), .clk_o(cpu_clk_o));
    clkstop_gate #(.N(N_BUS), .STOPPABLE(1'b1)) u_bus_gate (
        .clk_i(bus_clk_i), .rst_n_i(rst_n_i), .stop_s_i(!bus_run_s),
        .pd_s_i(bus_pd_s), .clk_o(bus_clk_o));
    clkstop_gate #(.N(N_EXEMPT), .STOPPABLE(1'b0)) u_bus_exempt (
        .clk_i(bus_clk_i), .rst_n_i(rst_n_i), .stop_s_i(!bus_run_s),
        .pd_s_i(bus_pd_s), .clk_o(exempt_clk));

    assign bus_free_o  = exempt_clk[0];
    assign bus_early_o = exempt_clk[1];

    // R6: a bus stop never silences the exempt pair.
    a_r6_exempt_running: assert property (@(negedge bus_clk_i) disable iff (!rst_n_i)
        $past(!bus_pd_s && !bus_run_s) |-> (bus_free_o && bus_early_o));

    // R7: a processor stop leaves the gated bus group running.
    a_r7_bus_unaffected: assert property (@(negedge bus_clk_i) disable iff (!rst_n_i)
        $past(!bus_pd_s && bus_run_s) |-> bus_clk_o == '1);
endmodule

// File: tb/clkstop_ctrl_tb.sv
module clkstop_ctrl_tb;
    localparam int CPU_PERIOD = 10;
    localparam int BUS_PERIOD = 30;
    localparam int N_CPU = 3;
    localparam int N_BUS = 5;

    logic cpu_clk = 1'b0, bus_clk = 1'b0, rst_n = 1'b0;
    logic cpu_stop_n = 1'b1, bus_stop_n = 1'b1, pd = 1'b0;
    logic [N_CPU-1:0] cpu_o;
    logic [N_BUS-1:0] bus_o;
    logic free_o, early_o;
    int checks = 0, errors = 0;

    always #(CPU_PERIOD/2) cpu_clk = ~cpu_clk;
    always #(BUS_PERIOD/2) bus_clk = ~bus_clk;

    clkstop_ctrl #(.N_CPU(N_CPU), .N_BUS(N_BUS), .SYNC_STAGES(2)) u_dut (
        .cpu_clk_i(cpu_clk), .bus_clk_i(bus_clk), .rst_n_i(rst_n),
        .cpu_stop_n_i(cpu_stop_n), .bus_stop_n_i(bus_stop_n), .pd_i(pd),
        .cpu_clk_o(cpu_o), .bus_clk_o(bus_o), .bus_free_o(free_o), .bus_early_o(early_o));

    function automatic logic grp_runs(input logic pd_v, input logic stop_n_v);
        return !pd_v && stop_n_v;
    endfunction

    function automatic logic [31:0] fill(input logic v, input int n);
        return v ? ((32'd1 << n) - 1) : 32'd0;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp_v);
        checks++;
        if (act !== exp_v) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h at %0t", req, act, exp_v, $time);
        end
    endtask

    // Both phases of both domains against the settled expectation.
    task automatic check_steady();
        logic cr, br, er;
        string tc, tb, te;
        cr = grp_runs(pd, cpu_stop_n);
        br = grp_runs(pd, bus_stop_n);
        er = !pd;
        tc = pd ? "R8" : (cr ? "R1" : "R2");
        tb = pd ? "R8" : (br ? "R7" : "R2");
        te = pd ? "R8" : "R6";
        @(posedge cpu_clk); #2;
        chk(tc, cpu_o, fill(cr, N_CPU));
        @(negedge cpu_clk); #2;
        chk("R2", cpu_o, 0);
        @(posedge bus_clk); #5;
        chk(tb, bus_o, fill(br, N_BUS));
        chk(te, {free_o, early_o}, fill(er, 2));
        @(negedge bus_clk); #5;
        chk("R2", {bus_o, free_o, early_o}, 0);
    endtask

    task automatic cpu_latency(input logic nv);
        @(negedge cpu_clk); #1; cpu_stop_n = nv;
        @(posedge cpu_clk);
        @(posedge cpu_clk); #2;
        chk("R3", cpu_o, fill(!nv, N_CPU));
        @(posedge cpu_clk); #1;
        chk("R3", cpu_o, fill(nv, N_CPU));
        #3;
        chk("R5", cpu_o, fill(nv, N_CPU));
    endtask

    task automatic bus_latency(input logic nv);
        @(negedge bus_clk); #1; bus_stop_n = nv;
        @(posedge bus_clk);
        @(posedge bus_clk); #5;
        chk("R4", bus_o, fill(!nv, N_BUS));
        @(posedge bus_clk); #1;
        chk("R4", bus_o, fill(nv, N_BUS));
        chk("R6", {free_o, early_o}, 2'b11);
        #12;
        chk("R5", bus_o, fill(nv, N_BUS));
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog actual hung expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_c10c));
        #103 rst_n = 1'b1;
        // R1: running out of reset
        check_steady();

        // Processor group stop/restart, bus group watched for R7
        cpu_latency(1'b0);
        @(posedge bus_clk); #5;
        chk("R7", bus_o, fill(1'b1, N_BUS));
        chk("R7", {free_o, early_o}, 2'b11);
        check_steady();
        cpu_latency(1'b1);

        // Bus group stop/restart, exempt pair watched for R6, processor for R7
        bus_latency(1'b0);
        @(posedge cpu_clk); #2;
        chk("R7", cpu_o, fill(1'b1, N_CPU));
        check_steady();
        bus_latency(1'b1);

        // R8: power-down with requests released and with requests asserted
        @(negedge cpu_clk); #1; pd = 1'b1;
        #(5*BUS_PERIOD);
        check_steady();
        cpu_stop_n = 1'b0; bus_stop_n = 1'b0;
        #(5*BUS_PERIOD);
        check_steady();
        pd = 1'b0;
        #(5*BUS_PERIOD);
        check_steady();
        cpu_stop_n = 1'b1; bus_stop_n = 1'b1;
        #(5*BUS_PERIOD);
        check_steady();

        // Seeded random combinations
        for (int it = 0; it < 30; it++) begin
            @(negedge cpu_clk); #1;
            cpu_stop_n = 1'($urandom_range(0, 1));
            bus_stop_n = 1'($urandom_range(0, 1));
            pd         = ($urandom_range(0, 3) == 0);
            #(5*BUS_PERIOD);
            check_steady();
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule